// File: doc/BRIEF.md
# Endian-Selectable Width-Down Bus Matcher

This block connects the 36-bit head of a show-ahead FIFO to a narrow read port. Each 36-bit word is delivered as two 18-bit pieces (word mode) or four 9-bit pieces (byte mode). The order of the pieces is either most-significant-first or least-significant-first. The FIFO side offers the head word with a valid flag. The block returns a pop strobe in the cycle that consumes the last piece of that word.

The narrow side has a read enable, an active-low chip select and a registered 18-bit data output. A read loads the next piece into the output register on the rising clock edge. The bus size and the piece order are captured while master reset is low and held afterwards. Partial reset clears the output register and the piece position, and keeps the captured configuration.

Top module: `narrow_bus_matcher`

## Requirements
- R1: In word mode (size select low) with the order select low, the two reads of a word deliver bits [17:0] and then bits [35:18].
- R2: In word mode with the order select high, the two reads of a word deliver bits [35:18] and then bits [17:0].
- R3: In byte mode (size select high) with the order select low, the four reads of a word deliver bits [8:0], [17:9], [26:18] and [35:27], in that order.
- R4: In byte mode with the order select high, the four reads of a word deliver bits [35:27], [26:18], [17:9] and [8:0], in that order.
- R5: In byte mode, bits [17:9] of the narrow output are always zero.
- R6: A read happens only on a rising edge where read enable is high, chip select is low and the FIFO head is valid. Any other edge leaves the output and the piece position unchanged.
- R7: The pop strobe is high, combinationally, exactly in the cycle of a read that takes the last piece of the current word (the second in word mode, the fourth in byte mode). The next read then takes the first piece of the next word.
- R8: The size and order selects are sampled on every edge while master reset is low. Changes to them after master reset is released have no effect.
- R9: Partial reset (low) clears the output to zero and the piece position to the first piece, and keeps the size and order configuration. A read requested in the same cycle is ignored and does not pop.
- R10: Master reset (low) clears the output to zero and the piece position to the first piece, with no pop.
- R11: A piece appears on the output after the rising edge of its read. It stays there until the next read or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| mrst_n | input | 1 | Master reset, active low, synchronous; captures the configuration |
| prst_n | input | 1 | Partial reset, active low, synchronous; keeps the configuration |
| size_byte | input | 1 | Bus size select: 1 = 9-bit byte pieces, 0 = 18-bit word pieces |
| msb_first | input | 1 | Order select: 1 = most significant piece first |
| wide_data | input | 36 | FIFO head word |
| wide_valid | input | 1 | FIFO head word is valid |
| wide_pop | output | 1 | Consume the FIFO head word (last piece read this cycle) |
| rd_en | input | 1 | Narrow read enable, active high |
| cs_n | input | 1 | Narrow chip select, active low |
| nar_data | output | 18 | Registered narrow output piece |

## Verification
Two functions can meet on one clock edge: a partial reset and a narrow read. That read may be the one that would take the last piece and raise the pop. The bench provokes this by reading part way into a word and then asserting partial reset with read enable high and chip select low in the same cycle. It checks that the pop stays low and that the output becomes zero on that edge. It also checks that the following reads restart the same head word at its first piece, in the order captured at master reset.

// File: rtl/nbm_pkg.sv
package nbm_pkg;

  // Physical lane that a logical piece position maps to.
  function automatic int lane_order(int pos, int count, logic msb_first);
    return msb_first ? (count - 1 - pos) : pos;
  endfunction

  // Number of narrow pieces per wide word for the chosen size.
  function automatic int piece_count(logic byte_mode, int wide_w, int word_w, int byte_w);
    return byte_mode ? (wide_w / byte_w) : (wide_w / word_w);
  endfunction

endpackage

// File: rtl/nbm_cfg_latch.sv
module nbm_cfg_latch (
  input  logic clk,
  input  logic mrst_n,
  input  logic size_byte,
  input  logic msb_first,
  output logic byte_mode_q,
  output logic msb_first_q
);

  // Sampled on every edge of master reset, frozen afterwards.
  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      byte_mode_q <= size_byte;
      msb_first_q <= msb_first;
    end
  end

  // R8: configuration frozen once master reset is released
  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!mrst_n)
    $past(mrst_n) |-> ($stable(byte_mode_q) && $stable(msb_first_q)));

endmodule

// File: rtl/nbm_piece_ctr.sv
module nbm_piece_ctr #(
  parameter int WIDE_W = 36,
  parameter int WORD_W = 18,
  parameter int BYTE_W = 9,
  localparam int BYTE_PIECES = WIDE_W / BYTE_W,
  localparam int IDX_W = $clog2(BYTE_PIECES)
) (
  input  logic             clk,
  input  logic             clear,
  input  logic             rd_fire,
  input  logic             byte_mode,
  output logic [IDX_W-1:0] idx,
  output logic             last_piece
);

  logic [IDX_W-1:0] last_idx;

  always_comb begin
    last_idx   = IDX_W'(nbm_pkg::piece_count(byte_mode, WIDE_W, WORD_W, BYTE_W) - 1);
    last_piece = (idx == last_idx);
  end

  always_ff @(posedge clk) begin
    if (clear)
      idx <= '0;
    else if (rd_fire)
      idx <= last_piece ? '0 : idx + 1'b1;
  end

  // R7: after the last piece is taken, the next word starts at its first piece
  assert_wrap_after_last_R7: assert property (@(posedge clk) disable iff (clear)
    (rd_fire && last_piece) |=> (idx == '0));

  // R6: position holds without a read
  assert_idx_hold_R6: assert property (@(posedge clk) disable iff (clear)
    !rd_fire |=> $stable(idx));

endmodule

// File: rtl/nbm_lane_mux.sv
module nbm_lane_mux #(
  parameter int WIDE_W = 36,
  parameter int WORD_W = 18,
  parameter int BYTE_W = 9,
  localparam int WORD_PIECES = WIDE_W / WORD_W,
  localparam int BYTE_PIECES = WIDE_W / BYTE_W,
  localparam int IDX_W = $clog2(BYTE_PIECES),
  localparam int WIDX_W = $clog2(WORD_PIECES)
) (
  input  logic [WIDE_W-1:0] wide,
  input  logic [IDX_W-1:0]  idx,
  input  logic              byte_mode,
  input  logic              msb_first,
  output logic [WORD_W-1:0] piece
);

  logic [BYTE_W-1:0] byte_lane [BYTE_PIECES];
  logic [WORD_W-1:0] word_lane [WORD_PIECES];
  logic [IDX_W-1:0]  eff_b;
  logic [WIDX_W-1:0] eff_w;

  for (genvar b = 0; b < BYTE_PIECES; b++) begin : g_byte
    assign byte_lane[b] = wide[b*BYTE_W +: BYTE_W];
  end

  for (genvar w = 0; w < WORD_PIECES; w++) begin : g_word
    assign word_lane[w] = wide[w*WORD_W +: WORD_W];
  end

  always_comb begin
    eff_b = IDX_W'(nbm_pkg::lane_order(int'(idx), BYTE_PIECES, msb_first));
    eff_w = WIDX_W'(nbm_pkg::lane_order(int'(idx), WORD_PIECES, msb_first));
    if (byte_mode)
      piece = {{(WORD_W-BYTE_W){1'b0}}, byte_lane[eff_b]};
    else
      piece = word_lane[eff_w];
  end

endmodule

// File: rtl/narrow_bus_matcher.sv
module narrow_bus_matcher #(
  parameter int WIDE_W = 36,
  parameter int WORD_W = 18,
  parameter int BYTE_W = 9
) (
  input  logic              clk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              size_byte,
  input  logic              msb_first,
  input  logic [WIDE_W-1:0] wide_data,
  input  logic              wide_valid,
  output logic              wide_pop,
  input  logic              rd_en,
  input  logic              cs_n,
  output logic [WORD_W-1:0] nar_data
);

  localparam int BYTE_PIECES = WIDE_W / BYTE_W;
  localparam int IDX_W = $clog2(BYTE_PIECES);

  // Named internal events
  logic             byte_mode_q;
  logic             msb_first_q;
  logic             clear;
  logic             rd_fire;
  logic             last_piece;
  logic [IDX_W-1:0] idx;
  logic [WORD_W-1:0] piece;
  logic [WORD_W-1:0] nar_q;

  assign clear    = !mrst_n || !prst_n;
  assign rd_fire  = rd_en && !cs_n && wide_valid && !clear;
  assign wide_pop = rd_fire && last_piece;
  assign nar_data = nar_q;

  nbm_cfg_latch u_cfg (
    .clk         (clk),
    .mrst_n      (mrst_n),
    .size_byte   (size_byte),
    .msb_first   (msb_first),
    .byte_mode_q (byte_mode_q),
    .msb_first_q (msb_first_q)
  );

  nbm_piece_ctr #(.WIDE_W(WIDE_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_ctr (
    .clk        (clk),
    .clear      (clear),
    .rd_fire    (rd_fire),
    .byte_mode  (byte_mode_q),
    .idx        (idx),
    .last_piece (last_piece)
  );

  nbm_lane_mux #(.WIDE_W(WIDE_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_mux (
    .wide      (wide_data),
    .idx       (idx),
    .byte_mode (byte_mode_q),
    .msb_first (msb_first_q),
    .piece     (piece)
  );

  always_ff @(posedge clk) begin
    if (clear)
      nar_q <= '0;
    else if (rd_fire)
      nar_q <= piece;
  end

  // R6 / R11: output holds between reads
  assert_out_hold_R6: assert property (@(posedge clk) disable iff (clear)
    !rd_fire |=> $stable(nar_data));

  // R5: upper bits of the narrow bus stay zero in byte mode
  assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!mrst_n)
    byte_mode_q |-> (nar_data[WORD_W-1:BYTE_W] == '0));

  // R9: partial reset empties the output and blocks the pop
  assert_prst_clear_R9: assert property (@(posedge clk) disable iff (!mrst_n)
    !prst_n |=> (nar_data == '0 && idx == '0));

  assert_prst_no_pop_R9: assert property (@(posedge clk) disable iff (!mrst_n)
    !prst_n |-> !wide_pop);

  // R10: master reset empties the output and position
  assert_mrst_clear_R10: assert property (@(posedge clk)
    !mrst_n |=> (nar_data == '0 && idx == '0));

endmodule

// File: tb/tb_narrow_bus_matcher.sv
module tb_narrow_bus_matcher;

  logic        clk = 1'b0;
  logic        mrst_n = 1'b0;
  logic        prst_n = 1'b1;
  logic        size_byte = 1'b0;
  logic        msb_first = 1'b0;
  logic [35:0] wide_data = '0;
  logic        wide_valid = 1'b0;
  logic        wide_pop;
  logic        rd_en = 1'b0;
  logic        cs_n = 1'b1;
  logic [17:0] nar_data;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [35:0] wq [16];
  int wn = 0;
  int wh = 0;

  always #2.5 clk = ~clk;

  narrow_bus_matcher dut (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .size_byte(size_byte),
    .msb_first(msb_first), .wide_data(wide_data), .wide_valid(wide_valid),
    .wide_pop(wide_pop), .rd_en(rd_en), .cs_n(cs_n), .nar_data(nar_data)
  );

  task automatic check(string req, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Expected piece k of word w, from the size and order rules
  function automatic logic [35:0] exp_piece(logic [35:0] w, int k, bit bm, bit mf);
    int n;
    int sz;
    int pos;
    logic [35:0] mask;
    n    = bm ? 4 : 2;
    sz   = bm ? 9 : 18;
    mask = bm ? 36'h1FF : 36'h3FFFF;
    pos  = mf ? (n - 1 - k) : k;
    return (w >> (pos * sz)) & mask;
  endfunction

  task automatic present();
    wide_valid = (wh < wn);
    wide_data  = (wh < wn) ? wq[wh] : 36'h0;
  endtask

  task automatic do_master_reset(bit bm, bit mf);
    @(negedge clk);
    mrst_n = 1'b0; size_byte = bm; msb_first = mf; rd_en = 1'b0; cs_n = 1'b1;
    repeat (3) @(negedge clk);
    mrst_n = 1'b1;
  endtask

  // One enabled read; checks pop before the edge and data after it
  task automatic do_read(string req, logic [35:0] exp, bit exp_pop);
    @(negedge clk);
    present();
    rd_en = 1'b1; cs_n = 1'b0;
    #1;
    check({req, " pop"}, {35'b0, wide_pop}, {35'b0, exp_pop});
    @(posedge clk);
    #1;
    check({req, " data"}, {18'b0, nar_data}, exp);
    if (exp_pop) wh++;
    @(negedge clk);
    rd_en = 1'b0; cs_n = 1'b1;
    present();
  endtask

  task automatic load_words(logic [35:0] seed, int n);
    for (int i = 0; i < n; i++) wq[i] = seed ^ (36'h1_2345_6789 * (i + 1));
    wn = n; wh = 0;
    present();
  endtask

  task automatic t_reset_state();
    do_master_reset(1'b0, 1'b0);
    @(posedge clk); #1;
    check("R10 out zero", {18'b0, nar_data}, 36'h0);
    check("R10 no pop", {35'b0, wide_pop}, 36'h0);
  endtask

  task automatic t_stream(string req, bit bm, bit mf, logic [35:0] seed);
    int n;
    n = bm ? 4 : 2;
    do_master_reset(bm, mf);
    load_words(seed, 3);
    for (int w = 0; w < 3; w++) begin
      for (int k = 0; k < n; k++) begin
        do_read(req, exp_piece(wq[w], k, bm, mf), k == n - 1);
        if (bm) check("R5 upper zero", {27'b0, nar_data[17:9]}, 36'h0);
      end
    end
  endtask

  task automatic t_no_read();
    logic [17:0] held;
    do_master_reset(1'b1, 1'b0);
    load_words(36'hA_5A5A_5A5A, 2);
    do_read("R3 first", exp_piece(wq[0], 0, 1, 0), 0);
    held = nar_data;
    // cs_n high, rd_en high
    @(negedge clk); rd_en = 1'b1; cs_n = 1'b1; #1;
    check("R6 cs high no pop", {35'b0, wide_pop}, 36'h0);
    @(posedge clk); #1;
    check("R6 cs high hold", {18'b0, nar_data}, {18'b0, held});
    // rd_en low, cs_n low
    @(negedge clk); rd_en = 1'b0; cs_n = 1'b0;
    @(posedge clk); #1;
    check("R11 rd low hold", {18'b0, nar_data}, {18'b0, held});
    // enabled but head not valid
    @(negedge clk); rd_en = 1'b1; cs_n = 1'b0; wide_valid = 1'b0;
    @(posedge clk); #1;
    check("R6 invalid hold", {18'b0, nar_data}, {18'b0, held});
    @(negedge clk); rd_en = 1'b0; cs_n = 1'b1;
    // position unchanged: next read gives piece 1
    do_read("R6 resume", exp_piece(wq[0], 1, 1, 0), 0);
    do_read("R6 resume", exp_piece(wq[0], 2, 1, 0), 0);
    do_read("R7 last", exp_piece(wq[0], 3, 1, 0), 1);
    do_read("R7 next word", exp_piece(wq[1], 0, 1, 0), 0);
  endtask

  task automatic t_cfg_hold();
    do_master_reset(1'b1, 1'b1);
    @(negedge clk); size_byte = 1'b0; msb_first = 1'b0;
    load_words(36'h9_8765_4321, 1);
    for (int k = 0; k < 4; k++)
      do_read("R8 cfg held", exp_piece(wq[0], k, 1, 1), k == 3);
  endtask

  task automatic t_partial();
    do_master_reset(1'b0, 1'b1);
    load_words(36'hF_0F0F_1234, 2);
    do_read("R2 first", exp_piece(wq[0], 0, 0, 1), 0);
    // partial reset and last-piece read in the same cycle
    @(negedge clk); prst_n = 1'b0; rd_en = 1'b1; cs_n = 1'b0; #1;
    check("R9 no pop on prst", {35'b0, wide_pop}, 36'h0);
    @(posedge clk); #1;
    check("R9 out cleared", {18'b0, nar_data}, 36'h0);
    @(negedge clk); prst_n = 1'b1; rd_en = 1'b0; cs_n = 1'b1;
    size_byte = 1'b1; msb_first = 1'b0;
    do_read("R9 restart keeps cfg", exp_piece(wq[0], 0, 0, 1), 0);
    do_read("R9 restart keeps cfg", exp_piece(wq[0], 1, 0, 1), 1);
    do_read("R9 next word", exp_piece(wq[1], 0, 0, 1), 0);
  endtask

  initial begin
    t_reset_state();
    t_stream("R1 word lsb-first", 1'b0, 1'b0, 36'h1_1111_2222);
    t_stream("R2 word msb-first", 1'b0, 1'b1, 36'h3_C3C3_0F0F);
    t_stream("R3 byte lsb-first", 1'b1, 1'b0, 36'h7_6543_210F);
    t_stream("R4 byte msb-first", 1'b1, 1'b1, 36'hE_DCBA_9876);
    t_no_read();
    t_cfg_hold();
    t_partial();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule